// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block is the input stage of an interrupt controller. It takes a group of raw interrupt lines and keeps one request bit per line. Each line is either edge triggered or level triggered. The choice comes from a per-line trigger-mode register. Software writes that register, and a fixed per-instance write mask forces to edge mode every bit that may not be level triggered. The default mask suits the primary instance. A secondary instance is built by overriding the mask parameter.

Every line passes through a synchronizer before any decision is taken. After that, a per-line cell compares the synchronized level with the level it stored on the previous clock. The cell sets, holds or clears the request bit from that comparison.

The request vector goes out three ways. The first output is raw, with every latched bit. The second is filtered through an externally supplied mask register and feeds the priority resolver. The third shows which latched requests are currently masked. The acknowledge logic uses a one-cycle strobe with a line index to retire an edge request. A separate initialization strobe forgets all stored previous levels.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_n` is low and directly after it, `req_vec`, `req_unmasked`, `req_masked` and `trig_mode` are all zero, and all stored previous levels are low.
- R2: A cycle with `trig_wr_en` high loads `trig_mode` with `trig_wr_data & WRITE_MASK`. The default `WRITE_MASK` is 8'hF8, so bits 0 to 2 always read back 0. Bit value 1 means level mode and 0 means edge mode.
- R3: For a line in level mode, the request bit equals the synchronized input level. A high input sets it and a low input clears it.
- R4: For a line in edge mode, the request bit is set only when the synchronized level is high and the stored previous level is low. A low input does not clear the request.
- R5: A cycle with `ack_en` high clears the request of line `ack_id` if that line is in edge mode. A line in level mode keeps its request. A new rising edge on the same line in the same cycle wins over the clear.
- R6: A line whose `mask_in` bit is 1 still latches its request in `req_vec`. That request appears in `req_masked` and not in `req_unmasked`, so `req_unmasked = req_vec & ~mask_in` and `req_masked = req_vec & mask_in`.
- R7: A cycle with `init_clr` high clears every stored previous level without touching the requests. An edge-mode line that is held high therefore sets its request again on the next clock.
- R8: A change on `line_in` shows on `req_vec` after exactly SYNC_STAGES+1 rising clock edges, which is 3 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | N_LINES | Raw asynchronous interrupt line levels |
| trig_wr_en | input | 1 | Write strobe for the trigger-mode register |
| trig_wr_data | input | N_LINES | Trigger-mode write value (1 = level) |
| mask_in | input | N_LINES | Mask register contents (1 = masked) |
| ack_en | input | 1 | Acknowledge strobe from the acknowledge logic |
| ack_id | input | ID_W | Index of the acknowledged line |
| init_clr | input | 1 | Initialization strobe; clears the stored previous levels |
| trig_mode | output | N_LINES | Current trigger-mode register |
| req_vec | output | N_LINES | Latched requests, masked or not |
| req_unmasked | output | N_LINES | Requests eligible for priority resolution |
| req_masked | output | N_LINES | Latched requests that are currently masked |

## Verification
A wrong stored previous level shows up on the very next rising edge of that line. It either produces a request without an edge, or it misses an edge entirely, so `req_vec` differs from the expected value three clocks after the input change. A wrong trigger-mode bit shows in two places: at once on `trig_mode`, and on `req_vec` the first time that line goes low or is acknowledged. A request that was wrongly cleared or kept shows on `req_vec` in the cycle after the acknowledge strobe, and it stays wrong until the line toggles. The stimulus table walks each of these paths, and the directed tests cover the exact latency and the re-trigger after initialization.

// File: rtl/irql_pkg.sv
package irql_pkg;

   // Trigger-mode encoding of one bit of the trigger-mode register
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   // Largest supported line count (keeps the ack index small)
   localparam int unsigned MAX_LINES = 64;

   // Minimum number of synchronizer flops for metastability settling
   localparam int unsigned MIN_SYNC = 2;

endpackage : irql_pkg

// File: rtl/irql_sync.sv
module irql_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule : irql_sync

// File: rtl/irql_trig_reg.sv
module irql_trig_reg #(
   parameter int unsigned     WIDTH = 8,
   parameter logic [WIDTH-1:0] WMASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] mode_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)     mode_q <= '0;
      else if (wr_en) mode_q <= wr_data & WMASK;
   end

endmodule : irql_trig_reg

// File: rtl/irql_line_cell.sv
module irql_line_cell
   import irql_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lvl,
   input  trig_e mode,
   input  logic  ack_hit,
   input  logic  init_clr,
   output logic  req_q,
   output logic  prev_q
);

   logic rise;

   assign rise = lvl & ~prev_q;

   // Previous level: follows the line, forced low by initialization
   always_ff @(posedge clk) begin
      if (!rst_n)        prev_q <= 1'b0;
      else if (init_clr) prev_q <= 1'b0;
      else               prev_q <= lvl;
   end

   // Request bit: level lines track the input, edge lines are sticky
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (mode == TRIG_LEVEL) begin
         req_q <= lvl;
      end else if (rise) begin
         req_q <= 1'b1;
      end else if (ack_hit) begin
         req_q <= 1'b0;
      end
   end

endmodule : irql_line_cell

// File: rtl/irq_req_latch.sv
module irq_req_latch
   import irql_pkg::*;
#(
   parameter int unsigned       N_LINES     = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [N_LINES-1:0] WRITE_MASK = 8'hF8,
   localparam int unsigned      ID_W        = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] line_in,
   input  logic               trig_wr_en,
   input  logic [N_LINES-1:0] trig_wr_data,
   input  logic [N_LINES-1:0] mask_in,
   input  logic               ack_en,
   input  logic [ID_W-1:0]    ack_id,
   input  logic               init_clr,
   output logic [N_LINES-1:0] trig_mode,
   output logic [N_LINES-1:0] req_vec,
   output logic [N_LINES-1:0] req_unmasked,
   output logic [N_LINES-1:0] req_masked
);

   // Elaboration-time parameter checks
   generate
      if (N_LINES < 2 || N_LINES > MAX_LINES) begin : g_bad_lines
         $error("irq_req_latch: N_LINES out of range");
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("irq_req_latch: SYNC_STAGES below minimum");
      end
   endgenerate

   logic [N_LINES-1:0] sync_lvl;
   logic [N_LINES-1:0] prev_lvl;

   irql_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (line_in),
      .q_sync  (sync_lvl)
   );

   irql_trig_reg #(
      .WIDTH (N_LINES),
      .WMASK (WRITE_MASK)
   ) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (trig_wr_en),
      .wr_data (trig_wr_data),
      .mode_q  (trig_mode)
   );

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         logic  hit;
         trig_e mode_i;

         assign hit    = ack_en && (ack_id == ID_W'(i));
         assign mode_i = trig_e'(trig_mode[i]);

         irql_line_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (sync_lvl[i]),
            .mode     (mode_i),
            .ack_hit  (hit),
            .init_clr (init_clr),
            .req_q    (req_vec[i]),
            .prev_q   (prev_lvl[i])
         );
      end
   endgenerate

   assign req_unmasked = req_vec & ~mask_in;
   assign req_masked   = req_vec &  mask_in;

endmodule : irq_req_latch

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
   parameter int unsigned       N_LINES    = 8,
   parameter int unsigned       ID_W       = 3,
   parameter logic [N_LINES-1:0] WRITE_MASK = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack_en,
   input logic [ID_W-1:0]    ack_id,
   input logic               init_clr,
   input logic [N_LINES-1:0] trig_mode,
   input logic [N_LINES-1:0] req_vec,
   input logic [N_LINES-1:0] sync_lvl,
   input logic [N_LINES-1:0] prev_lvl
);

   logic [N_LINES-1:0] ack_vec;

   always_comb begin
      ack_vec = '0;
      if (ack_en) ack_vec = N_LINES'(1) << ack_id;
   end

   // R2
   wmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode & ~WRITE_MASK) == '0);

   // R3
   level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_vec ^ $past(sync_lvl)) & trig_mode & $past(trig_mode)) == '0);

   // R4
   edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec & ~$past(req_vec) & ~trig_mode & ~$past(trig_mode)
       & ~($past(sync_lvl) & ~$past(prev_lvl))) == '0);

   // R5
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_vec) & ~$past(ack_vec) & ~trig_mode & ~$past(trig_mode)
       & ~req_vec) == '0);

   // R7
   init_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_clr) |-> (prev_lvl == '0));

endmodule : irq_req_latch_chk

bind irq_req_latch irq_req_latch_chk #(
   .N_LINES    (N_LINES),
   .ID_W       (ID_W),
   .WRITE_MASK (WRITE_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack_en    (ack_en),
   .ack_id    (ack_id),
   .init_clr  (init_clr),
   .trig_mode (trig_mode),
   .req_vec   (req_vec),
   .sync_lvl  (sync_lvl),
   .prev_lvl  (prev_lvl)
);

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] line_in = '0;
   logic       trig_wr_en = 1'b0;
   logic [7:0] trig_wr_data = '0;
   logic [7:0] mask_in = '0;
   logic       ack_en = 1'b0;
   logic [2:0] ack_id = '0;
   logic       init_clr = 1'b0;
   logic [7:0] trig_mode, req_vec, req_unmasked, req_masked;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_req_latch u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_in      (line_in),
      .trig_wr_en   (trig_wr_en),
      .trig_wr_data (trig_wr_data),
      .mask_in      (mask_in),
      .ack_en       (ack_en),
      .ack_id       (ack_id),
      .init_clr     (init_clr),
      .trig_mode    (trig_mode),
      .req_vec      (req_vec),
      .req_unmasked (req_unmasked),
      .req_masked   (req_masked)
   );

   // Entry: {line_in, mask_in, ack_en, ack_id, expected req_vec}
   // trig_mode is 8'hF8 throughout: lines 0..2 edge, 3..7 level
   localparam int NV = 12;
   localparam logic [27:0] VEC [NV] = '{
      {8'h00, 8'h00, 1'b0, 3'd0, 8'h00},
      {8'h09, 8'h00, 1'b0, 3'd0, 8'h09},  // R3 R4 rise
      {8'h00, 8'h01, 1'b0, 3'd0, 8'h01},  // R4 low keeps edge req, R3 clears
      {8'h00, 8'h00, 1'b1, 3'd0, 8'h00},  // R5 edge ack
      {8'h11, 8'h10, 1'b0, 3'd0, 8'h11},  // R6 masked level line latches
      {8'h11, 8'h00, 1'b1, 3'd4, 8'h11},  // R5 level ack ignored
      {8'h11, 8'h00, 1'b1, 3'd0, 8'h10},  // R5 edge ack, held high no retrigger
      {8'h03, 8'h02, 1'b0, 3'd0, 8'h02},  // R4 only the new edge sets
      {8'h80, 8'h82, 1'b0, 3'd0, 8'h82},  // R6 all masked
      {8'h80, 8'h00, 1'b1, 3'd1, 8'h80},
      {8'h06, 8'h04, 1'b0, 3'd0, 8'h06},
      {8'h00, 8'h00, 1'b1, 3'd2, 8'h02}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic write_trig(input logic [7:0] v);
      trig_wr_data = v;
      trig_wr_en   = 1'b1;
      tick(1);
      trig_wr_en   = 1'b0;
   endtask

   task automatic pulse_ack(input logic [2:0] id);
      ack_id = id;
      ack_en = 1'b1;
      tick(1);
      ack_en = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      tick(2);
      // R1 reset state
      check("R1 req_vec", req_vec, 8'h00);
      check("R1 trig_mode", trig_mode, 8'h00);
      check("R1 req_unmasked", req_unmasked, 8'h00);
      rst_n = 1'b1;
      tick(1);

      // R2 write mask
      write_trig(8'hFF);
      check("R2 mask FF", trig_mode, 8'hF8);

      for (int v = 0; v < NV; v++) begin
         logic [7:0] lin, msk, exp;
         logic       aen;
         logic [2:0] aid;
         {lin, msk, aen, aid, exp} = VEC[v];
         line_in = lin;
         mask_in = msk;
         tick(4);
         if (aen) pulse_ack(aid);
         check($sformatf("R3/R4/R5 vec%0d req_vec", v), req_vec, exp);
         check($sformatf("R6 vec%0d req_unmasked", v), req_unmasked, exp & ~msk);
         check($sformatf("R6 vec%0d req_masked", v), req_masked, exp & msk);
      end
      mask_in = '0;

      // R8 latency: level line 5 rises; state is req=02, lines low
      line_in = 8'h20;
      tick(2);
      check("R8 not yet after 2 edges", req_vec, 8'h02);
      tick(1);
      check("R8 visible after 3 edges", req_vec, 8'h22);
      line_in = 8'h00;
      tick(4);

      // R7 init re-triggers a held-high edge line
      line_in = 8'h01;
      tick(4);
      pulse_ack(3'd0);
      tick(2);
      check("R7 no retrigger before init", req_vec, 8'h02);
      init_clr = 1'b1;
      tick(1);
      init_clr = 1'b0;
      check("R7 init keeps requests", req_vec, 8'h02);
      tick(1);
      check("R7 retrigger after init", req_vec, 8'h03);

      // R2 low bits never become level
      write_trig(8'h07);
      check("R2 mask 07", trig_mode, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1 actual=hang expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule : irq_req_latch_tb